// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block sits on the access stream of a parallel SRAM-style memory and looks for a hidden command: a fixed, ordered series of six reads. The first five reads must land at fixed key addresses. The sixth read selects the command. One terminal address turns the automatic power-down save feature off, and another turns it back on. Any access that leaves the key before it is complete cancels the attempt, and no command is issued.

The block keeps two copies of the feature setting. The active setting follows recognised commands at once. The persisted setting only takes the active value when the store engine reports that a manual store has finished. A pending flag is high while the two copies differ, so the system knows a store is needed to keep the change across power loss. The memory array, the store engine and the power sensing are outside this block.

Top module: `cmd_seq_detect`

## Requirements
- R1: After reset, both the active setting and the persisted setting are 1 (enabled), the command pulses are 0, and pending is 0.
- R2: An access is sampled only in a cycle where acc_vld_i is 1. In cycles where acc_vld_i is 0, the address and the read/write flag have no effect. acc_wr_i = 1 marks a write and acc_wr_i = 0 marks a read.
- R3: The five lead reads, in this order, are 15-bit addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F. They must be followed directly by a sixth read, with no other access in between.
- R4: If the sixth read is at 0x03F8, dis_cmd_o is 1 for exactly one cycle, and active_o becomes 0 on the same clock edge.
- R5: If the sixth read is at 0x07F0, en_cmd_o is 1 for exactly one cycle, and active_o becomes 1 on the same clock edge.
- R6: Some accesses break a key in progress: a read at an address other than the expected one, a sixth read at neither terminal address, or any write. Such an access issues no command and leaves the settings unchanged.
- R7: If the breaking access is itself a read at 0x0E38, it counts as the first step of a new key.
- R8: The persisted setting changes only when store_done_i is 1. In that cycle it takes the active value on the same edge.
- R9: pending_o is 1 exactly when active_o differs from saved_o.
- R10: dis_cmd_o and en_cmd_o are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_vld_i | input | 1 | Qualified access strobe (chip-enable or output-enable read forms ORed) |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 15 | Access address |
| store_done_i | input | 1 | Manual store finished |
| active_o | output | 1 | Active feature setting (1 = enabled) |
| saved_o | output | 1 | Persisted feature setting |
| dis_cmd_o | output | 1 | One-cycle disable command pulse |
| en_cmd_o | output | 1 | One-cycle enable command pulse |
| pending_o | output | 1 | Active and persisted settings differ |

## Verification
The in-RTL assertions check several rules on every cycle:
- the two command pulses never overlap;
- each pulse lasts a single cycle;
- the active setting moves only together with a pulse, and in the matching direction;
- the persisted copy changes only on a store-done;
- the step counter stays in range and holds still while the strobe is low.

Other behaviour can only be shown by the bench scenarios. These include the exact key values and their order, abort on a wrong read or a write, restart on 0x0E38, and the pending flag across random interleavings. The bench checks them against a reference model.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int unsigned ADDR_W  = 15;
  localparam int unsigned LEAD_N  = 5;
  localparam int unsigned STEP_W  = $clog2(LEAD_N + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;

  function automatic addr_t lead_addr(input step_t idx);
    case (idx)
      3'd0: lead_addr = 15'h0E38;
      3'd1: lead_addr = 15'h31C7;
      3'd2: lead_addr = 15'h03E0;
      3'd3: lead_addr = 15'h3C1F;
      default: lead_addr = 15'h303F;
    endcase
  endfunction

  localparam addr_t TERM_DIS = 15'h03F8;
  localparam addr_t TERM_EN  = 15'h07F0;

  typedef enum logic [1:0] {CMD_NONE, CMD_DIS, CMD_EN} cmd_e;
endpackage

// File: rtl/cmd_seq_track.sv
module cmd_seq_track
  import cmd_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  acc_vld_i,
  input  logic  acc_wr_i,
  input  addr_t acc_addr_i,
  output cmd_e  cmd_o
);
  step_t step_q, step_d;
  cmd_e  cmd_d;

  always_comb begin
    step_d = step_q;
    cmd_d  = CMD_NONE;
    if (acc_vld_i) begin
      if (acc_wr_i) begin
        step_d = '0;
      end else if (step_q == step_t'(LEAD_N)) begin
        step_d = '0;
        if (acc_addr_i == TERM_DIS)     cmd_d = CMD_DIS;
        else if (acc_addr_i == TERM_EN) cmd_d = CMD_EN;
        else if (acc_addr_i == lead_addr('0)) step_d = step_t'(1);
      end else if (acc_addr_i == lead_addr(step_q)) begin
        step_d = step_q + step_t'(1);
      end else if (acc_addr_i == lead_addr('0)) begin
        step_d = step_t'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  assign cmd_o = cmd_d;

  a_r3_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= step_t'(LEAD_N));
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_vld_i |=> $stable(step_q));
  a_r6_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && acc_wr_i) |=> step_q == '0);
endmodule

// File: rtl/cmd_seq_state.sv
module cmd_seq_state
  import cmd_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic store_done_i,
  output logic active_o,
  output logic saved_o,
  output logic dis_cmd_o,
  output logic en_cmd_o
);
  logic active_q, saved_q, dis_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      saved_q  <= 1'b1;
      dis_q    <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      dis_q <= (cmd_i == CMD_DIS);
      en_q  <= (cmd_i == CMD_EN);
      if (cmd_i == CMD_DIS)     active_q <= 1'b0;
      else if (cmd_i == CMD_EN) active_q <= 1'b1;
      // store copies the value active before this edge's command
      if (store_done_i) saved_q <= active_q;
    end
  end

  assign active_o  = active_q;
  assign saved_o   = saved_q;
  assign dis_cmd_o = dis_q;
  assign en_cmd_o  = en_q;

  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dis_q && en_q));
  a_r4_dis_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_q |=> !dis_q);
  a_r5_en_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> !en_q);
  a_r4_dis_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_q |-> !active_q);
  a_r5_en_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> active_q);
  a_r6_active_only_on_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_q) |-> (dis_q || en_q));
  a_r8_saved_on_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(store_done_i) |-> $stable(saved_q));
endmodule

// File: rtl/cmd_seq_detect.sv
module cmd_seq_detect
  import cmd_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_vld_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              store_done_i,
  output logic              active_o,
  output logic              saved_o,
  output logic              dis_cmd_o,
  output logic              en_cmd_o,
  output logic              pending_o
);
  cmd_e cmd;

  cmd_seq_track u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_vld_i  (acc_vld_i),
    .acc_wr_i   (acc_wr_i),
    .acc_addr_i (acc_addr_i),
    .cmd_o      (cmd)
  );

  cmd_seq_state u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd),
    .store_done_i (store_done_i),
    .active_o     (active_o),
    .saved_o      (saved_o),
    .dis_cmd_o    (dis_cmd_o),
    .en_cmd_o     (en_cmd_o)
  );

  assign pending_o = active_o ^ saved_o;

  a_r8_saved_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_done_i |=> saved_o == $past(active_o));
endmodule

// File: tb/cmd_seq_detect_bench.sv
module cmd_seq_detect_bench;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic vld = 0, wr = 0, sd = 0;
  logic [14:0] addr = 0;
  logic act, sav, dis, en, pend;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_seq_detect u_cmd_seq_detect (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(vld), .acc_wr_i(wr),
    .acc_addr_i(addr), .store_done_i(sd), .active_o(act), .saved_o(sav),
    .dis_cmd_o(dis), .en_cmd_o(en), .pending_o(pend));

  // reference model
  int m_step = 0;
  logic m_act = 1, m_sav = 1, m_dis = 0, m_en = 0;

  function automatic logic [14:0] key(int i);
    case (i)
      0: return 15'h0E38; 1: return 15'h31C7; 2: return 15'h03E0;
      3: return 15'h3C1F; default: return 15'h303F;
    endcase
  endfunction

  task automatic model_step(logic v, logic w, logic [14:0] a, logic s);
    logic na = m_act;
    m_dis = 0; m_en = 0;
    if (s) m_sav = m_act;
    if (v) begin
      if (w) m_step = 0;
      else if (m_step == 5) begin
        m_step = 0;
        if (a == 15'h03F8) begin m_dis = 1; na = 0; end
        else if (a == 15'h07F0) begin m_en = 1; na = 1; end
        else if (a == key(0)) m_step = 1;
      end else if (a == key(m_step)) m_step++;
      else if (a == key(0)) m_step = 1;
      else m_step = 0;
    end
    m_act = na;
  endtask

  task automatic chk(string r, logic [4:0] got, logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s act/sav/dis/en/pend got=%b exp=%b t=%0t", r, got, exp, $time);
    end
  endtask

  task automatic drive(string r, logic v, logic w, logic [14:0] a, logic s = 0);
    vld = v; wr = w; addr = a; sd = s;
    @(posedge clk);
    model_step(v, w, a, s);
    #1;
    chk(r, {act, sav, dis, en, pend}, {m_act, m_sav, m_dis, m_en, m_act ^ m_sav});
    vld = 0; sd = 0;
  endtask

  task automatic lead(string r);
    for (int i = 0; i < 5; i++) drive(r, 1, 0, key(i));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    #(CLK_PERIOD*2+2);
    chk("R1", {act, sav, dis, en, pend}, 5'b11000);
    rst_n = 1;
    @(negedge clk);
    // R4 disable
    lead("R3"); drive("R4", 1, 0, 15'h03F8);
    drive("R9", 0, 0, 0);
    // R8 store commits
    drive("R8", 0, 0, 0, 1);
    // R5 enable
    lead("R3"); drive("R5", 1, 0, 15'h07F0);
    drive("R8", 0, 0, 0, 1);
    // R2 idle cycles with key addresses ignored, then key still works
    lead("R2"); drive("R2", 0, 1, 15'h0000); drive("R2", 0, 0, 15'h1234);
    drive("R4", 1, 0, 15'h03F8);
    // R6 write aborts
    lead("R6"); drive("R6", 1, 1, 15'h07F0); drive("R6", 1, 0, 15'h07F0);
    // R6 wrong sixth
    lead("R6"); drive("R6", 1, 0, 15'h0001); drive("R6", 1, 0, 15'h07F0);
    // R6 wrong middle read
    drive("R6", 1, 0, key(0)); drive("R6", 1, 0, key(1)); drive("R6", 1, 0, 15'h0777);
    drive("R6", 1, 0, key(3));
    // R7 restart on 0x0E38
    drive("R7", 1, 0, key(0)); drive("R7", 1, 0, key(1)); drive("R7", 1, 0, key(0));
    for (int i = 1; i < 5; i++) drive("R7", 1, 0, key(i));
    drive("R7", 1, 0, 15'h07F0);
    // R7 sixth at 0x0E38 restarts
    lead("R7"); drive("R7", 1, 0, key(0));
    for (int i = 1; i < 5; i++) drive("R7", 1, 0, key(i));
    drive("R7", 1, 0, 15'h03F8);
    // R8 store in the same cycle as a command copies prior value
    lead("R8"); drive("R8", 1, 0, 15'h07F0, 1);
    drive("R9", 0, 0, 0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 9);
      logic [14:0] a;
      if (k < 5) a = key(m_step < 5 ? m_step : 0);
      else if (k == 5) a = ($urandom_range(0, 1) != 0) ? 15'h03F8 : 15'h07F0;
      else if (k == 6) a = key(0);
      else a = 15'($urandom);
      drive("R10", $urandom_range(0, 7) != 0, $urandom_range(0, 15) == 0, a,
            $urandom_range(0, 20) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule